// File: doc/BRIEF.md
# Tagged Response Tracker

This block watches a request/response channel where each request carries a small tag and the matching response returns that tag, possibly out of order relative to other outstanding requests. It keeps one tracking slot per tag value, made of an outstanding flag and a cycle counter. From these slots it checks that every request is answered in time, that every response belongs to an outstanding request, and that no tag is issued again while it is still outstanding.

Each kind of error produces a one-cycle pulse on its own output, together with the tag that caused it. The current set of outstanding tags is visible as a bit vector. The block only observes traffic. It never generates requests or responses, and it carries no payload.

Top module: `tag_tracker`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `live_mask` is all zero, all three error pulses are low, and `err_tag` is zero.
- R2: A request (`ask_valid` high, tag on `ask_tag`) sampled at a clock edge sets bit `ask_tag` of `live_mask` from that edge on.
- R3: A response (`ans_valid` high, tag on `ans_tag`) for a live tag, sampled 1 to 20 edges after the request edge, clears that bit of `live_mask` at that edge and raises no error.
- R4: A request or response for one tag leaves the `live_mask` bits of every other tag unchanged, so responses may return in any order.
- R5: A response whose tag is not live raises `err_orphan` for exactly the one cycle after the sampling edge, with `err_tag` equal to that tag.
- R6: A request whose tag is already live, with no response for the same tag in that cycle, raises `err_reuse` for one cycle with `err_tag` equal to that tag. The entry stays live, and its 20-cycle window restarts from this request.
- R7: If no matching response is sampled by the 20th edge after the request edge, `err_timeout` is high for the cycle after that 20th edge, with `err_tag` equal to the tag. The live bit clears at the same edge.
- R8: A timeout is reported only once per request. No further pulse follows for that tag unless it is requested again.
- R9: A request and a response for the same live tag in the same cycle close the old entry and open a new one. The tag stays live, and no error is raised.
- R10: When several errors occur at one edge, every matching pulse is raised, and `err_tag` carries the lowest-numbered offending tag.
- R11: In any cycle with no error pulse, `err_tag` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ask_valid | input | 1 | A request is present this cycle |
| ask_tag | input | 4 | Tag of the request |
| ans_valid | input | 1 | A response is present this cycle |
| ans_tag | input | 4 | Tag carried by the response |
| err_timeout | output | 1 | One-cycle pulse: a request was not answered within 20 cycles |
| err_orphan | output | 1 | One-cycle pulse: a response arrived for a tag that was not live |
| err_reuse | output | 1 | One-cycle pulse: a request reused a live tag |
| err_tag | output | 4 | Lowest offending tag while any pulse is high, otherwise zero |
| live_mask | output | 16 | One bit per tag, set while that tag is outstanding |

## Verification
Within a single slot, the window expiry can coincide with a fresh request for the same tag, and a response can coincide with a request for the same tag. The first case is provoked by re-issuing a tag at exactly its 20th edge. The bench expects both the timeout and the reuse pulse, the tag to stay live, and a second timeout exactly 20 edges later. The second case is driven both on a live tag, where no error is expected and the tag must stay live, and on an idle tag, where only the orphan pulse is expected and the tag must become live. A timeout and an orphan on different tags are also made to land on the same edge, to check that both pulses rise and that the lower tag is reported.

// File: rtl/tag_track_pkg.sv
package tag_track_pkg;

  // Error flags produced by one tracking slot in a cycle
  typedef struct packed {
    logic timeout;
    logic orphan;
    logic reuse;
  } err_flags_t;

  // True on the cycle whose edge is the last one inside the response window
  function automatic logic window_closing(input int unsigned age,
                                          input int unsigned limit);
    return (age + 1) == limit;
  endfunction

  // Next value of the age counter of a live slot
  function automatic int unsigned age_advance(input int unsigned age);
    return age + 1;
  endfunction

endpackage

// File: rtl/tag_track_entry.sv
module tag_track_entry
  import tag_track_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter int IDX   = 0,
  parameter int LIMIT = 20,
  parameter int AGE_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ask_valid,
  input  logic [TAG_W-1:0] ask_tag,
  input  logic             ans_valid,
  input  logic [TAG_W-1:0] ans_tag,
  output logic             live_o,
  output err_flags_t       flags_o
);

  logic             live_q;
  logic [AGE_W-1:0] age_q;

  // Named events for this slot
  logic set_w;
  logic hit_w;
  logic expire_w;

  assign set_w    = ask_valid && (ask_tag == TAG_W'(IDX));
  assign hit_w    = ans_valid && (ans_tag == TAG_W'(IDX));
  assign expire_w = live_q && !hit_w && window_closing(32'(age_q), LIMIT);

  always_comb begin
    flags_o.orphan  = hit_w && !live_q;
    flags_o.reuse   = set_w && live_q && !hit_w;
    flags_o.timeout = expire_w;
  end

  // A request always opens a fresh entry; response or expiry closes it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      age_q  <= '0;
    end else if (set_w) begin
      live_q <= 1'b1;
      age_q  <= '0;
    end else if (hit_w || expire_w) begin
      live_q <= 1'b0;
      age_q  <= '0;
    end else if (live_q) begin
      age_q  <= AGE_W'(age_advance(32'(age_q)));
    end
  end

  assign live_o = live_q;

  // Requirement R2: a request makes the slot live at the next edge
  p_set_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_w |=> live_q);

  // Requirement R4: with no event of its own the slot keeps its state
  p_hold_other_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_w && !hit_w && !expire_w) |=> (live_q == $past(live_q)));

  // Requirement R7: a live slot never counts beyond its window
  p_age_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (32'(age_q) < LIMIT));

  // Requirement R8: after an expiry the slot is closed unless re-requested
  p_expire_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_w && !set_w) |=> !live_q);

  // Requirement R9: a same-cycle request and response on a live slot keep it live at age zero
  p_swap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_w && hit_w && live_q) |=> (live_q && age_q == '0));

endmodule

// File: rtl/tag_track_pick.sv
module tag_track_pick #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req_vec,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);

  // Lowest set bit wins: scan from the top so the lowest index is written last
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_vec[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/tag_tracker.sv
module tag_tracker
  import tag_track_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter int LIMIT = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ask_valid,
  input  logic [TAG_W-1:0]      ask_tag,
  input  logic                  ans_valid,
  input  logic [TAG_W-1:0]      ans_tag,
  output logic                  err_timeout,
  output logic                  err_orphan,
  output logic                  err_reuse,
  output logic [TAG_W-1:0]      err_tag,
  output logic [(1<<TAG_W)-1:0] live_mask
);

  localparam int NTAGS = 1 << TAG_W;
  localparam int AGE_W = $clog2(LIMIT + 1);

  logic [NTAGS-1:0] live_vec;
  logic [NTAGS-1:0] to_vec;
  logic [NTAGS-1:0] orphan_vec;
  logic [NTAGS-1:0] reuse_vec;
  logic [NTAGS-1:0] any_err_vec;
  logic             pick_any;
  logic [TAG_W-1:0] pick_idx;

  for (genvar g = 0; g < NTAGS; g++) begin : g_slot
    err_flags_t flags_w;

    tag_track_entry #(
      .TAG_W (TAG_W),
      .IDX   (g),
      .LIMIT (LIMIT),
      .AGE_W (AGE_W)
    ) slot_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ask_valid (ask_valid),
      .ask_tag   (ask_tag),
      .ans_valid (ans_valid),
      .ans_tag   (ans_tag),
      .live_o    (live_vec[g]),
      .flags_o   (flags_w)
    );

    assign to_vec[g]     = flags_w.timeout;
    assign orphan_vec[g] = flags_w.orphan;
    assign reuse_vec[g]  = flags_w.reuse;
  end

  assign any_err_vec = to_vec | orphan_vec | reuse_vec;

  tag_track_pick #(
    .N     (NTAGS),
    .IDX_W (TAG_W)
  ) pick_i (
    .req_vec (any_err_vec),
    .any_o   (pick_any),
    .idx_o   (pick_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_timeout <= 1'b0;
      err_orphan  <= 1'b0;
      err_reuse   <= 1'b0;
      err_tag     <= '0;
    end else begin
      err_timeout <= |to_vec;
      err_orphan  <= |orphan_vec;
      err_reuse   <= |reuse_vec;
      err_tag     <= pick_any ? pick_idx : '0;
    end
  end

  assign live_mask = live_vec;

  // Requirement R5: a response to an idle tag is flagged at the next cycle
  p_orphan_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ans_valid && !live_mask[ans_tag]) |=> err_orphan);

  // Requirement R6: a repeated live tag is flagged and stays live
  p_reuse_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ask_valid && live_mask[ask_tag] && !(ans_valid && ans_tag == ask_tag))
      |=> (err_reuse && live_mask[$past(ask_tag)]));

  // Requirement R9: request plus response on a live tag raises nothing
  p_swap_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ask_valid && ans_valid && ask_tag == ans_tag && live_mask[ask_tag])
      |=> (!err_reuse && !err_orphan));

  // Requirement R10: the reported tag is no higher than a same-cycle orphan tag
  p_lowest_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ans_valid && !live_mask[ans_tag]) |=> (err_tag <= $past(ans_tag)));

  // Requirement R11: the tag output rests at zero when nothing is flagged
  p_tag_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_timeout || err_orphan || err_reuse) |-> (err_tag == '0));

endmodule

// File: tb/tag_tracker_tb_top.sv
`timescale 1ns/1ps
module tag_tracker_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ask_valid = 1'b0;
  logic [3:0]  ask_tag = '0;
  logic        ans_valid = 1'b0;
  logic [3:0]  ans_tag = '0;
  logic        err_timeout;
  logic        err_orphan;
  logic        err_reuse;
  logic [3:0]  err_tag;
  logic [15:0] live_mask;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  tag_tracker dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ask_valid   (ask_valid),
    .ask_tag     (ask_tag),
    .ans_valid   (ans_valid),
    .ans_tag     (ans_tag),
    .err_timeout (err_timeout),
    .err_orphan  (err_orphan),
    .err_reuse   (err_reuse),
    .err_tag     (err_tag),
    .live_mask   (live_mask)
  );

  // Vector layout: {ask_v, ask_tag, ans_v, ans_tag, {timeout,orphan,reuse}, err_tag, live_mask}
  localparam int NV = 16;
  localparam logic [32:0] VEC [NV] = '{
    {1'b1, 4'd3, 1'b0, 4'd0, 3'b000, 4'd0, 16'h0008},  // R2 open tag 3
    {1'b1, 4'd5, 1'b0, 4'd0, 3'b000, 4'd0, 16'h0028},  // R2 open tag 5
    {1'b0, 4'd0, 1'b1, 4'd5, 3'b000, 4'd0, 16'h0008},  // R3 R4 close 5 before 3
    {1'b0, 4'd0, 1'b1, 4'd9, 3'b010, 4'd9, 16'h0008},  // R5 orphan 9
    {1'b1, 4'd3, 1'b0, 4'd0, 3'b001, 4'd3, 16'h0008},  // R6 reuse 3
    {1'b1, 4'd7, 1'b1, 4'd3, 3'b000, 4'd0, 16'h0080},  // R4 open 7, close 3
    {1'b1, 4'd7, 1'b1, 4'd7, 3'b000, 4'd0, 16'h0080},  // R9 swap on live 7
    {1'b1, 4'd1, 1'b1, 4'd2, 3'b010, 4'd2, 16'h0082},  // R5 orphan 2, open 1
    {1'b1, 4'd4, 1'b1, 4'd4, 3'b010, 4'd4, 16'h0092},  // R9 R5 idle 4: orphan, then live
    {1'b1, 4'd2, 1'b0, 4'd0, 3'b000, 4'd0, 16'h0096},  // R2 open 2
    {1'b1, 4'd7, 1'b1, 4'd6, 3'b011, 4'd6, 16'h0096},  // R10 reuse 7 + orphan 6
    {1'b0, 4'd0, 1'b1, 4'd1, 3'b000, 4'd0, 16'h0094},  // R3 close 1
    {1'b0, 4'd0, 1'b1, 4'd7, 3'b000, 4'd0, 16'h0014},  // R3 close 7
    {1'b0, 4'd0, 1'b1, 4'd4, 3'b000, 4'd0, 16'h0004},  // R3 close 4
    {1'b0, 4'd0, 1'b1, 4'd2, 3'b000, 4'd0, 16'h0000},  // R3 close 2
    {1'b0, 4'd0, 1'b0, 4'd0, 3'b000, 4'd0, 16'h0000}   // R11 idle
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // Drive at a falling edge, pass one rising edge, return at the next falling edge
  task automatic step(input logic av, input logic [3:0] at,
                      input logic rv, input logic [3:0] rt);
    ask_valid = av; ask_tag = at; ans_valid = rv; ans_tag = rt;
    @(posedge clk);
    @(negedge clk);
    ask_valid = 1'b0; ans_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 4'd0, 1'b0, 4'd0);
  endtask

  task automatic chk_flags(input string req, input logic [2:0] f, input logic [3:0] t,
                           input logic [15:0] lv);
    chk(req, {29'd0, err_timeout, err_orphan, err_reuse}, {29'd0, f});
    chk(req, {28'd0, err_tag}, {28'd0, t});
    chk(req, {16'd0, live_mask}, {16'd0, lv});
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // R1: reset state
    @(negedge clk);
    chk_flags("R1 in reset", 3'b000, 4'd0, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_flags("R1 after release", 3'b000, 4'd0, 16'h0000);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      step(VEC[v][32], VEC[v][31:28], VEC[v][27], VEC[v][26:23]);
      chk_flags($sformatf("R2-table vector %0d", v), VEC[v][22:20], VEC[v][19:16], VEC[v][15:0]);
    end

    // R7: no response, expiry exactly after the 20th edge
    step(1'b1, 4'd10, 1'b0, 4'd0);
    idle(19);
    chk_flags("R7 edge 19 quiet", 3'b000, 4'd0, 16'h0400);
    idle(1);
    chk_flags("R7 timeout at edge 20", 3'b100, 4'd10, 16'h0000);
    // R8: reported once
    idle(1);
    chk_flags("R8 pulse ends", 3'b000, 4'd0, 16'h0000);
    idle(25);
    chk_flags("R8 no repeat", 3'b000, 4'd0, 16'h0000);

    // R3: response on the 20th edge is still in time
    step(1'b1, 4'd11, 1'b0, 4'd0);
    idle(19);
    step(1'b0, 4'd0, 1'b1, 4'd11);
    chk_flags("R3 reply at edge 20", 3'b000, 4'd0, 16'h0000);

    // R6 + R7 same edge: re-request at the expiry edge restarts the window
    step(1'b1, 4'd12, 1'b0, 4'd0);
    idle(19);
    step(1'b1, 4'd12, 1'b0, 4'd0);
    chk_flags("R6 R7 timeout and reuse together", 3'b101, 4'd12, 16'h1000);
    idle(19);
    chk_flags("R6 window restarted", 3'b000, 4'd0, 16'h1000);
    idle(1);
    chk_flags("R7 second expiry", 3'b100, 4'd12, 16'h0000);

    // R10: timeout on 9 and orphan on 2 at the same edge
    step(1'b1, 4'd9, 1'b0, 4'd0);
    idle(19);
    step(1'b0, 4'd0, 1'b1, 4'd2);
    chk_flags("R10 timeout 9 with orphan 2", 3'b110, 4'd2, 16'h0000);
    idle(1);
    chk_flags("R11 tag back to zero", 3'b000, 4'd0, 16'h0000);

    // R1: reset in mid-traffic clears live tags
    step(1'b1, 4'd15, 1'b0, 4'd0);
    chk_flags("R2 open 15", 3'b000, 4'd0, 16'h8000);
    rst_n = 1'b0;
    #1;
    chk_flags("R1 async reset", 3'b000, 4'd0, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    chk_flags("R1 stays clear", 3'b000, 4'd0, 16'h0000);

    summary();
  end

endmodule